// File: doc/BRIEF.md
# Disk Controller Host Command and Status Port

This block is the host-side front end of a two-drive disk controller. It offers two byte-wide ports that share one write strobe and one read strobe and are told apart by a select input. One is a parameter port backed by an 8-byte buffer, which has its own write and read pointers. The other is a command port on writes and a status port on reads. Each byte written to the command port is one of two kinds. An auxiliary command is a group of flag bits that take effect at once. A full command carries an opcode, is handed to the execution logic as a one-cycle start pulse, and keeps the controller busy until that logic returns a completion pulse.

The block owns the completion-end flags, the service-request flag and its mask, the busy interlock, and the latched unit address. It also accumulates per-unit interrupt status reported by the execution logic, drives the single interrupt line, and holds the mode byte and the geometry limits captured by the specify command. Sector data movement and drive mechanics belong to other blocks.

Top module: `dkc_host_if`

## Requirements
- R1: Every write to the command port, auxiliary or full, returns both parameter pointers to zero in the following cycle.
- R2: A command byte with upper nibble 0 is auxiliary, and its low bits act independently. Bit 0 clears both completion-end flags. Bit 1 sets the service-request mask. Bit 2 clears the parameter pointers.
- R3: Auxiliary bit 3 (reset) clears all status flags, busy and the mask, and pulses abort_o for one cycle. It takes priority over a completion in the same cycle and leaves the accumulated unit status untouched.
- R4: A full command written while busy is dropped. There is no start pulse, and the flags, the opcode and the unit are left unchanged.
- R5: An accepted full command clears both completion-end flags, sets busy, pulses start_o in the next cycle, and presents its upper nibble on op_o.
- R6: An accepted full command latches unit_o from command bits 1:0, and drive_o follows bit 0. Opcodes 1 (sense interrupt status), 2 (specify) and 3 (detect error) leave the unit unchanged.
- R7: irq_o is high when either completion-end flag is set, or when service request is set and not masked.
- R8: Accepting opcode 1 drops service request, unless srq_set_i arrives in the same cycle. Its completion writes the accumulated unit status into buffer byte 0 and clears the accumulator. Bits reported in that same cycle are kept in the accumulator.
- R9: A status read returns bit 7 completion-end high, bit 6 completion-end low, bit 5 service request, bit 4 busy, bits 3:1 zero, and bit 0 equal to dma_req_i.
- R10: done_i while busy clears busy and the mask and sets completion-end high. It also sets completion-end low when done_err_i is high. done_i while idle has no effect.
- R11: Parameter writes store at the write pointer and advance it. Reads return the byte at the read pointer and advance it. Past 8 bytes, writes are discarded and reads return 0, and neither pointer wraps.
- R12: Accepting opcode 2 captures buffer byte 1 as mode_o, byte 3 as end_track_o and byte 4 as end_sector_o.
- R13: When a full command and done_i fall in the same cycle, the command is judged against the busy state before that cycle. It is therefore dropped, and the completion still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| port_sel_i | input | 1 | 1 selects the command/status port, 0 the parameter port |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data (combinational) |
| dma_req_i | input | 1 | DMA request flag, shown in status bit 0 |
| srq_set_i | input | 1 | Execution logic raises service request |
| ist_set_i | input | 1 | Execution logic reports unit interrupt status |
| ist_data_i | input | 8 | Unit interrupt status bits to accumulate |
| done_i | input | 1 | Completion pulse from the execution logic |
| done_err_i | input | 1 | Completion ended in error |
| start_o | output | 1 | One-cycle pulse for an accepted full command |
| op_o | output | 4 | Opcode of the current full command |
| unit_o | output | 2 | Latched unit address |
| drive_o | output | 1 | Latched logical drive |
| abort_o | output | 1 | One-cycle pulse that cancels the pending operation |
| busy_o | output | 1 | Controller busy |
| irq_o | output | 1 | Interrupt request |
| mode_o | output | 8 | Mode byte from specify |
| end_track_o | output | 8 | Ending track number from specify |
| end_sector_o | output | 8 | Ending sector number from specify |

## Verification
The collision that matters is a completion pulse landing in the same cycle as a command-port write. If the write is a full command, the busy state before the edge decides, so the command is dropped while busy clears and completion-end high rises. If the write is an auxiliary reset, the reset wins and no completion flag appears. The bench forces both cases by driving done_i and the write together. It also puts srq_set_i against an accepted sense-interrupt-status command and a status report against its completion. The judging uses start_o, status-port reads and parameter-port reads, compared with a bench model that applies the stated priorities.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

  typedef enum logic [3:0] {
    OP_AUX   = 4'h0,
    OP_SIS   = 4'h1,
    OP_SPEC  = 4'h2,
    OP_DERR  = 4'h3,
    OP_SUS   = 4'h4,
    OP_RECAL = 4'h5,
    OP_SEEK  = 4'h6,
    OP_FMT   = 4'h7,
    OP_VID   = 4'h8,
    OP_RID   = 4'h9,
    OP_RDIAG = 4'hA,
    OP_RDATA = 4'hB,
    OP_CHECK = 4'hC,
    OP_SCAN  = 4'hD,
    OP_VDATA = 4'hE,
    OP_WDATA = 4'hF
  } op_e;

  // auxiliary flag bits, msb first: reset, clear buffer, mask srq, clear ce
  typedef struct packed {
    logic rst;
    logic clr_buf;
    logic mask_srq;
    logic clr_ce;
  } aux_t;

  localparam int ST_CEH = 7;
  localparam int ST_CEL = 6;
  localparam int ST_SRQ = 5;
  localparam int ST_CB  = 4;
  localparam int ST_DRQ = 0;

  // controller-level opcodes do not touch the unit latch
  function automatic logic is_ctrl_op(op_e op);
    return (op == OP_SIS) || (op == OP_SPEC) || (op == OP_DERR);
  endfunction

endpackage

// File: rtl/dkc_cmd_decode.sv
module dkc_cmd_decode
  import dkc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int UNIT_W = 2
) (
  input  logic [DW-1:0]     cmd_i,
  output logic              is_aux_o,
  output aux_t              aux_o,
  output op_e               op_o,
  output logic              ctrl_op_o,
  output logic [UNIT_W-1:0] unit_o
);

  assign op_o      = op_e'(cmd_i[DW-1 -: 4]);
  assign is_aux_o  = (op_o == OP_AUX);
  assign aux_o     = aux_t'(cmd_i[3:0]);
  assign ctrl_op_o = is_ctrl_op(op_o);
  assign unit_o    = cmd_i[UNIT_W-1:0];

endmodule

// File: rtl/dkc_param_buf.sv
module dkc_param_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ld0_i,
  input  logic [DW-1:0] ld0_data_i,
  input  logic          cap_spec_i,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] end_track_o,
  output logic [DW-1:0] end_sector_o
);

  localparam int PTR_W   = $clog2(DEPTH + 1);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int IDX_MOD = 1;
  localparam int IDX_ETN = 3;
  localparam int IDX_ESN = 4;
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic             w_ok, r_ok;

  assign w_ok    = wptr_q < LIMIT;
  assign r_ok    = rptr_q < LIMIT;
  assign rdata_o = r_ok ? mem_q[rptr_q[IDX_W-1:0]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_i && w_ok) wptr_q <= wptr_q + 1'b1;
      if (rd_i && r_ok) rptr_q <= rptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (g == 0 && ld0_i) mem_q[g] <= ld0_data_i;  // completion load wins
      else if (wr_i && w_ok && !clr_i && wptr_q[IDX_W-1:0] == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o       <= '0;
      end_track_o  <= '0;
      end_sector_o <= '0;
    end else if (cap_spec_i) begin
      mode_o       <= mem_q[IDX_MOD];
      end_track_o  <= mem_q[IDX_ETN];
      end_sector_o <= mem_q[IDX_ESN];
    end
  end

  AST_WPTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q <= LIMIT && rptr_q <= LIMIT);  // R11
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (wptr_q == '0 && rptr_q == '0));  // R1

endmodule

// File: rtl/dkc_status.sv
module dkc_status #(
  parameter int IST_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_aux_i,
  input  logic             clr_ce_i,
  input  logic             mask_i,
  input  logic             accept_i,
  input  logic             sis_accept_i,
  input  logic             done_i,
  input  logic             done_err_i,
  input  logic             srq_set_i,
  input  logic             ist_set_i,
  input  logic [IST_W-1:0] ist_data_i,
  input  logic             ist_clr_i,
  output logic             busy_o,
  output logic             ceh_o,
  output logic             cel_o,
  output logic             srq_o,
  output logic             mask_o,
  output logic             irq_o,
  output logic [IST_W-1:0] ist_o
);

  logic ceh_d, cel_d, srq_d, busy_d, mask_d;

  // aux clears first, completion applied last, aux reset overrides all
  always_comb begin
    ceh_d  = ceh_o;
    cel_d  = cel_o;
    srq_d  = srq_o;
    busy_d = busy_o;
    mask_d = mask_o;
    if (clr_ce_i || accept_i) begin
      ceh_d = 1'b0;
      cel_d = 1'b0;
    end
    if (mask_i)       mask_d = 1'b1;
    if (accept_i)     busy_d = 1'b1;
    if (sis_accept_i) srq_d  = 1'b0;
    if (srq_set_i)    srq_d  = 1'b1;
    if (done_i) begin
      busy_d = 1'b0;
      mask_d = 1'b0;
      ceh_d  = 1'b1;
      if (done_err_i) cel_d = 1'b1;
    end
    if (rst_aux_i) begin
      ceh_d  = 1'b0;
      cel_d  = 1'b0;
      srq_d  = 1'b0;
      busy_d = 1'b0;
      mask_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ceh_o  <= 1'b0;
      cel_o  <= 1'b0;
      srq_o  <= 1'b0;
      busy_o <= 1'b0;
      mask_o <= 1'b0;
      ist_o  <= '0;
    end else begin
      ceh_o  <= ceh_d;
      cel_o  <= cel_d;
      srq_o  <= srq_d;
      busy_o <= busy_d;
      mask_o <= mask_d;
      if (ist_clr_i)      ist_o <= ist_set_i ? ist_data_i : '0;
      else if (ist_set_i) ist_o <= ist_o | ist_data_i;
    end
  end

  assign irq_o = ceh_o | cel_o | (srq_o & ~mask_o);

  AST_DONE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !rst_aux_i) |=> (ceh_o && !busy_o && !mask_o && irq_o));  // R10
  AST_AUX_RST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_aux_i |=> !(ceh_o || cel_o || srq_o || busy_o || mask_o));  // R3
  AST_SIS_DROP_SRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sis_accept_i && !srq_set_i && !rst_aux_i) |=> !srq_o);  // R8

endmodule

// File: rtl/dkc_host_if.sv
module dkc_host_if
  import dkc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 8,
  parameter int UNIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              port_sel_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              dma_req_i,
  input  logic              srq_set_i,
  input  logic              ist_set_i,
  input  logic [DW-1:0]     ist_data_i,
  input  logic              done_i,
  input  logic              done_err_i,
  output logic              start_o,
  output logic [3:0]        op_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic              drive_o,
  output logic              abort_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic [DW-1:0]     mode_o,
  output logic [DW-1:0]     end_track_o,
  output logic [DW-1:0]     end_sector_o
);

  logic              cmd_wr, dat_wr, dat_rd;
  logic              is_aux, ctrl_op;
  aux_t              aux;
  op_e               dec_op, cur_op_q;
  logic [UNIT_W-1:0] dec_unit, unit_q;
  logic              aux_fire, aux_rst, full_wr, accept, done_ok, sis_done;
  logic              ceh, cel, srq, mask;
  logic [DW-1:0]     ist, buf_rdata, status;
  logic              start_q, abort_q;

  assign cmd_wr = wr_i & port_sel_i;
  assign dat_wr = wr_i & ~port_sel_i;
  assign dat_rd = rd_i & ~port_sel_i;

  dkc_cmd_decode #(.DW(DW), .UNIT_W(UNIT_W)) u_dec (
    .cmd_i     (wdata_i),
    .is_aux_o  (is_aux),
    .aux_o     (aux),
    .op_o      (dec_op),
    .ctrl_op_o (ctrl_op),
    .unit_o    (dec_unit)
  );

  assign aux_fire = cmd_wr & is_aux;
  assign aux_rst  = aux_fire & aux.rst;
  assign full_wr  = cmd_wr & ~is_aux;
  assign accept   = full_wr & ~busy_o;   // pre-edge busy decides
  assign done_ok  = done_i & busy_o & ~aux_rst;
  assign sis_done = done_ok & (cur_op_q == OP_SIS);

  dkc_status #(.IST_W(DW)) u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_aux_i    (aux_rst),
    .clr_ce_i     (aux_fire & aux.clr_ce),
    .mask_i       (aux_fire & aux.mask_srq),
    .accept_i     (accept),
    .sis_accept_i (accept & (dec_op == OP_SIS)),
    .done_i       (done_ok),
    .done_err_i   (done_err_i),
    .srq_set_i    (srq_set_i),
    .ist_set_i    (ist_set_i),
    .ist_data_i   (ist_data_i),
    .ist_clr_i    (sis_done),
    .busy_o       (busy_o),
    .ceh_o        (ceh),
    .cel_o        (cel),
    .srq_o        (srq),
    .mask_o       (mask),
    .irq_o        (irq_o),
    .ist_o        (ist)
  );

  dkc_param_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (cmd_wr | (aux_fire & aux.clr_buf)),
    .wr_i         (dat_wr),
    .wdata_i      (wdata_i),
    .rd_i         (dat_rd),
    .rdata_o      (buf_rdata),
    .ld0_i        (sis_done),
    .ld0_data_i   (ist),
    .cap_spec_i   (accept & (dec_op == OP_SPEC)),
    .mode_o       (mode_o),
    .end_track_o  (end_track_o),
    .end_sector_o (end_sector_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_op_q <= OP_AUX;
      unit_q   <= '0;
      start_q  <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      start_q <= accept;
      abort_q <= aux_rst;
      if (accept) begin
        cur_op_q <= dec_op;
        if (!ctrl_op) unit_q <= dec_unit;
      end
    end
  end

  always_comb begin
    status         = '0;
    status[ST_CEH] = ceh;
    status[ST_CEL] = cel;
    status[ST_SRQ] = srq;
    status[ST_CB]  = busy_o;
    status[ST_DRQ] = dma_req_i;
  end

  assign rdata_o = port_sel_i ? status : buf_rdata;
  assign start_o = start_q;
  assign abort_o = abort_q;
  assign op_o    = cur_op_q;
  assign unit_o  = unit_q;
  assign drive_o = unit_q[0];

  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_wr && busy_o) |=> !start_o);  // R4
  AST_ACCEPT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (start_o && busy_o));  // R5
  AST_UNIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && ctrl_op) |=> $stable(unit_o));  // R6
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o || $past(aux_rst));  // R3

endmodule

// File: tb/dkc_host_if_bench.sv
module dkc_host_if_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, port_sel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       dma_req_i = 1'b0, srq_set_i = 1'b0, ist_set_i = 1'b0;
  logic [7:0] ist_data_i = '0;
  logic       done_i = 1'b0, done_err_i = 1'b0;
  logic       start_o, drive_o, abort_o, busy_o, irq_o;
  logic [3:0] op_o;
  logic [1:0] unit_o;
  logic [7:0] mode_o, end_track_o, end_sector_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  dkc_host_if u_dkc_host_if (.*);

  int checks = 0, errors = 0;

  // reference model state
  bit       m_ceh, m_cel, m_srq, m_cb, m_mask;
  bit [7:0] m_buf [8];
  int       m_wp, m_rp;
  bit [1:0] m_unit;
  bit [3:0] m_op;
  bit [7:0] m_ist, m_mode, m_etn, m_esn;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_status(bit drq);
    return {m_ceh, m_cel, m_srq, m_cb, 3'b000, drq};
  endfunction

  function automatic bit exp_irq();
    return m_ceh | m_cel | (m_srq & ~m_mask);
  endfunction

  // one cycle carrying any mix of command write, completion, srq and ist
  task automatic cyc(bit cmd_en, bit [7:0] b, bit dn, bit err, bit sq, bit is_en, bit [7:0] isd);
    bit cb_pre, acc, rst, exp_start, exp_abort;
    @(negedge clk_i);
    wr_i = cmd_en; port_sel_i = 1'b1; wdata_i = b;
    done_i = dn; done_err_i = err; srq_set_i = sq; ist_set_i = is_en; ist_data_i = isd;
    cb_pre = m_cb; acc = 0; rst = 0;
    if (cmd_en) begin
      m_wp = 0; m_rp = 0;
      if (b[7:4] == 0) begin
        if (b[0]) begin m_ceh = 0; m_cel = 0; end
        if (b[1]) m_mask = 1;
        if (b[3]) rst = 1;
      end else if (!cb_pre) begin
        acc = 1; m_ceh = 0; m_cel = 0; m_cb = 1; m_op = b[7:4];
        if (b[7:4] > 3) m_unit = b[1:0];
        if (b[7:4] == 1) m_srq = 0;
        if (b[7:4] == 2) begin m_mode = m_buf[1]; m_etn = m_buf[3]; m_esn = m_buf[4]; end
      end
    end
    if (sq) m_srq = 1;
    if (dn && cb_pre && !rst) begin
      m_cb = 0; m_mask = 0; m_ceh = 1;
      if (err) m_cel = 1;
      if (m_op == 1) begin m_buf[0] = m_ist; m_ist = 0; end
    end
    if (is_en) m_ist |= isd;
    if (rst) begin m_ceh = 0; m_cel = 0; m_srq = 0; m_cb = 0; m_mask = 0; end
    exp_start = acc; exp_abort = rst;
    @(posedge clk_i); #2;
    wr_i = 0; done_i = 0; done_err_i = 0; srq_set_i = 0; ist_set_i = 0;
    chk("R5 start_o", start_o, exp_start);
    chk("R3 abort_o", abort_o, exp_abort);
    chk("R6 unit_o", {drive_o, unit_o}, {m_unit[0], m_unit});
    chk("R5 op_o", op_o, m_op);
    chk("R7 irq_o", irq_o, exp_irq());
  endtask

  task automatic stat_rd(string tag, bit drq);
    @(negedge clk_i);
    port_sel_i = 1'b1; rd_i = 1'b1; dma_req_i = drq; #1;
    chk(tag, rdata_o, exp_status(drq));
    @(posedge clk_i); #2; rd_i = 0;
  endtask

  task automatic dat_wr(bit [7:0] d);
    @(negedge clk_i);
    port_sel_i = 1'b0; wr_i = 1'b1; wdata_i = d;
    if (m_wp < 8) begin m_buf[m_wp] = d; m_wp++; end
    @(posedge clk_i); #2; wr_i = 0;
  endtask

  task automatic dat_rd(string tag);
    @(negedge clk_i);
    port_sel_i = 1'b0; rd_i = 1'b1; #1;
    chk(tag, rdata_o, (m_rp < 8) ? m_buf[m_rp] : 8'h00);
    if (m_rp < 8) m_rp++;
    @(posedge clk_i); #2; rd_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d7261));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // reset state
    stat_rd("R9 reset status", 1'b0);
    chk("R7 reset irq", irq_o, 1'b0);
    stat_rd("R9 drq bit", 1'b1);

    // R11 fill past the end, read past the end
    for (int i = 0; i < 10; i++) dat_wr(8'h30 + 8'(i));
    for (int i = 0; i < 10; i++) dat_rd("R11 buffer read");
    // R1 command write rewinds pointers
    cyc(1, 8'h00, 0, 0, 0, 0, 0);
    dat_rd("R1 rewound read");
    // R12 specify captures bytes 1,3,4
    cyc(1, 8'h00, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) dat_wr(8'hA0 + 8'(i));
    cyc(1, 8'h2F, 0, 0, 0, 0, 0);
    chk("R12 mode", mode_o, m_mode);
    chk("R12 end track", end_track_o, m_etn);
    chk("R12 end sector", end_sector_o, m_esn);
    chk("R6 specify keeps unit", unit_o, 2'b00);
    stat_rd("R5 busy after accept", 1'b0);
    // R4 dropped while busy
    cyc(1, 8'h63, 0, 0, 0, 0, 0);
    chk("R4 unit unchanged", unit_o, 2'b00);
    // R10 completion with error
    cyc(0, 8'h00, 1, 1, 0, 0, 0);
    stat_rd("R10 completion status", 1'b0);
    // R10 idle done ignored
    cyc(1, 8'h01, 0, 0, 0, 0, 0);
    cyc(0, 8'h00, 1, 0, 0, 0, 0);
    stat_rd("R10 idle done", 1'b0);
    // R7 mask only gates srq
    cyc(0, 8'h00, 0, 0, 1, 0, 0);
    chk("R7 srq irq", irq_o, 1'b1);
    cyc(1, 8'h02, 0, 0, 0, 0, 0);
    chk("R2 masked srq", irq_o, 1'b0);
    // R6 unit-level op latches unit
    cyc(1, 8'h67, 0, 0, 0, 1, 8'h41);
    chk("R6 drive", drive_o, 1'b1);
    cyc(0, 8'h00, 1, 0, 0, 1, 8'h02);
    // R8 SIS: drops srq, loads byte 0, new bits kept
    cyc(1, 8'h00, 0, 0, 1, 0, 0);
    cyc(1, 8'h10, 0, 0, 0, 0, 0);
    stat_rd("R8 srq dropped", 1'b0);
    cyc(0, 8'h00, 1, 0, 0, 1, 8'h80);
    dat_rd("R8 byte0 status");
    cyc(1, 8'h10, 0, 0, 1, 0, 0);
    stat_rd("R8 srq set wins", 1'b0);
    cyc(0, 8'h00, 1, 0, 0, 0, 0);
    dat_rd("R8 kept bits");
    // R13 full command with completion in one cycle
    cyc(1, 8'h45, 0, 0, 0, 0, 0);
    cyc(1, 8'h72, 1, 0, 0, 0, 0);
    stat_rd("R13 dropped, completed", 1'b0);
    // R3 reset beats completion
    cyc(1, 8'h50, 0, 0, 1, 0, 0);
    cyc(1, 8'h0A, 1, 1, 0, 0, 0);
    stat_rd("R3 reset status", 1'b0);
    // R2 aux clear ce
    cyc(1, 8'hC1, 0, 0, 0, 0, 0);
    cyc(0, 8'h00, 1, 1, 0, 0, 0);
    cyc(1, 8'h05, 0, 0, 0, 0, 0);
    stat_rd("R2 clear ce", 1'b0);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1: dat_wr(8'($urandom));
        2, 3: dat_rd("R11 random read");
        4: stat_rd("R9 random status", 1'($urandom));
        5: cyc(1, {4'h0, ($urandom_range(0, 7) == 0), 3'($urandom)}, 1'($urandom), 1'($urandom), 0, 0, 0);
        6: cyc(1, {4'($urandom_range(1, 15)), 4'($urandom)}, 0, 0, 0, 0, 0);
        7: cyc(0, 8'h00, 1, 1'($urandom), 0, 1'($urandom), 8'($urandom));
        8: cyc(1, {4'($urandom_range(1, 15)), 4'($urandom)}, 1, 1'($urandom), 1'($urandom), 0, 0);
        default: cyc(0, 8'h00, 0, 0, 1'($urandom), 1'($urandom), 8'($urandom));
      endcase
    end
    stat_rd("R9 final status", 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule